// File: doc/BRIEF.md
# Console Terminal Character Port

This block sits between a processor's I/O decode and a console terminal. It has two byte paths. Characters come in from a keyboard-style source and are latched into a receive buffer. Characters the processor writes are handed to a printer-style sink over a valid/ready handshake. Each path has a ready flag. The processor reads the receive buffer directly. It drops either flag with a function strobe, and it tests the flags through a combinational skip output.

One mode input sets the character treatment for both directions:
- Eight-bit mode passes every bit.
- Seven-bit mode drops bit 7.
- Teletype mode drops bit 7 and folds lowercase letters to uppercase. On receive only, teletype mode also sets bit 7 on the latched character.

A break from the keyboard side latches a zero byte. A character the sink stalls on stays presented until the sink accepts it.

Top module: `console_char_port`

## Requirements
- R1: After reset, rx_data is 0x00, rx_ready is 0, tx_ready is 1 and prn_valid is 0.
- R2: With mode = 2'b01 (eight-bit), a received byte is latched unchanged. A written byte is presented on prn_data unchanged.
- R3: With mode = 2'b00 (seven-bit), or with the spare code 2'b11, bit 7 is cleared in both directions and letter case is untouched.
- R4: With mode = 2'b10 (teletype), a received byte has bit 7 cleared. If the result lies in 0x61..0x7A, bit 5 is also cleared. Bit 7 is then set before the byte is latched.
- R5: With mode = 2'b10, the byte on prn_data has bit 7 cleared and codes 0x61..0x7A have bit 5 cleared. Bit 7 is never set on output.
- R6: A cycle with kb_break high latches 0x00 into rx_data and sets rx_ready one cycle later, whatever kb_data and mode are.
- R7: A new received byte overwrites rx_data even when rx_ready is still 1, and rx_ready stays 1.
- R8: A cycle with cpu_wr_en high captures cpu_wr_data. From the next cycle, tx_ready is 0 and prn_valid is 1.
- R9: While prn_valid is 1 and prn_ready is 0, prn_valid and prn_data hold and tx_ready stays 0. The cycle after a cycle with prn_valid and prn_ready both high shows prn_valid 0 and tx_ready 1.
- R10: When func_en is high, func_op bit 0 clears rx_ready and func_op bit 1 clears tx_ready on the next cycle. rx_data is left unchanged. A character arriving in the same cycle wins over the clear.
- R11: skip equals (skip_sel[0] and rx_ready) or (skip_sel[1] and tx_ready), combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 seven-bit, 01 eight-bit, 10 teletype, 11 as seven-bit |
| kb_valid | input | 1 | One-cycle strobe: kb_data holds a new character |
| kb_data | input | 8 | Received character from the keyboard side |
| kb_break | input | 1 | One-cycle strobe: break condition received |
| rx_data | output | 8 | Receive buffer as seen by the processor |
| rx_ready | output | 1 | Receive ready flag |
| cpu_wr_en | input | 1 | Processor write strobe for the transmit buffer |
| cpu_wr_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmit ready flag |
| func_en | input | 1 | Function strobe |
| func_op | input | 2 | Bit 0 clears rx_ready, bit 1 clears tx_ready |
| skip_sel | input | 2 | Bit 0 tests rx_ready, bit 1 tests tx_ready |
| skip | output | 1 | 1 when any selected flag is set |
| prn_valid | output | 1 | A character is offered to the sink |
| prn_data | output | 8 | Character offered to the sink, after mode treatment |
| prn_ready | input | 1 | Sink accepts the offered character |

## Verification
A wrong fold or mask in the receive path appears in rx_data one cycle after the keyboard strobe. The bench probes it at the letter-range edges 0x60, 0x61, 0x7A and 0x7B, and with bit 7 set on the input. A lost or stuck transmit busy state appears as prn_valid dropping during a stall, or as tx_ready returning before the sink accepts. Either shows within one cycle of the stall or of the handshake. Flag-clear and skip errors show as a wrong skip value in the same cycle as the select.

// File: rtl/cterm_pkg.sv
package cterm_pkg;

    localparam int CW = 8;

    typedef enum logic [1:0] {
        CM_SEVEN = 2'b00,
        CM_EIGHT = 2'b01,
        CM_TTY   = 2'b10,
        CM_SPARE = 2'b11
    } cmode_e;

    typedef struct packed {
        logic [CW-1:0] data;
        logic          rdy;
    } rx_st_t;

    typedef struct packed {
        logic [CW-1:0] hold;
        logic          busy;
        logic          rdy;
    } tx_st_t;

    // Lowercase letter range becomes uppercase by dropping bit 5.
    function automatic logic [CW-1:0] upcase(input logic [CW-1:0] c);
        logic [CW-1:0] r;
        r = c;
        if (c >= 8'h61 && c <= 8'h7A) r[5] = 1'b0;
        return r;
    endfunction

    function automatic logic [CW-1:0] treat_in(input logic [CW-1:0] c, input cmode_e m);
        logic [CW-1:0] r;
        case (m)
            CM_EIGHT: r = c;
            CM_TTY: begin
                r = upcase({1'b0, c[CW-2:0]});
                r[CW-1] = 1'b1;
            end
            default:  r = {1'b0, c[CW-2:0]};
        endcase
        return r;
    endfunction

    function automatic logic [CW-1:0] treat_out(input logic [CW-1:0] c, input cmode_e m);
        logic [CW-1:0] r;
        case (m)
            CM_EIGHT: r = c;
            CM_TTY:   r = upcase({1'b0, c[CW-2:0]});
            default:  r = {1'b0, c[CW-2:0]};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cterm_rx_path.sv
module cterm_rx_path
    import cterm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  cmode_e        mode,
    input  logic          kb_valid,
    input  logic [CW-1:0] kb_data,
    input  logic          kb_break,
    input  logic          clr_rdy,
    output logic [CW-1:0] rx_data,
    output logic          rx_ready
);

    rx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_rdy) st_d.rdy = 1'b0;
        if (kb_break) begin
            st_d.data = '0;
            st_d.rdy  = 1'b1;
        end else if (kb_valid) begin
            st_d.data = treat_in(kb_data, mode);
            st_d.rdy  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_data  = st_q.data;
    assign rx_ready = st_q.rdy;

    AST_RX_BREAK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        kb_break |=> (rx_data == '0) && rx_ready) else $error("break"); // R6
    AST_RX_TTY_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_valid && !kb_break && mode == CM_TTY) |=> rx_data[CW-1]) else $error("tty top"); // R4
    AST_RX_SEVEN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_valid && !kb_break && mode == CM_SEVEN) |=> !rx_data[CW-1]) else $error("seven top"); // R3
    AST_RX_CLR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rdy && !kb_valid && !kb_break) |=> !rx_ready && $stable(rx_data)) else $error("clr"); // R10

endmodule

// File: rtl/cterm_tx_path.sv
module cterm_tx_path
    import cterm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  cmode_e        mode,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          clr_rdy,
    output logic          tx_ready,
    output logic          prn_valid,
    output logic [CW-1:0] prn_data,
    input  logic          prn_ready
);

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy && prn_ready) begin
            st_d.busy = 1'b0;
            st_d.rdy  = 1'b1;
        end
        if (clr_rdy) st_d.rdy = 1'b0;
        if (wr_en) begin
            st_d.hold = wr_data;
            st_d.busy = 1'b1;
            st_d.rdy  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hold <= '0;
            st_q.busy <= 1'b0;
            st_q.rdy  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_ready  = st_q.rdy;
    assign prn_valid = st_q.busy;
    assign prn_data  = treat_out(st_q.hold, mode);

    AST_TX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_ready && prn_valid)) else $error("excl"); // R9
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (prn_valid && !prn_ready && !wr_en) |=> prn_valid) else $error("hold"); // R9
    AST_TX_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> prn_valid && !tx_ready) else $error("wr"); // R8
    AST_TX_TTY_NO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (prn_valid && mode == CM_TTY) |-> !prn_data[CW-1]) else $error("tty out"); // R5

endmodule

// File: rtl/cterm_flag_test.sv
module cterm_flag_test (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       rx_flag,
    input  logic       tx_flag,
    output logic       skip
);

    logic [1:0] flags;
    assign flags = {tx_flag, rx_flag};

    always_comb begin
        skip = 1'b0;
        for (int i = 0; i < 2; i++) begin
            if (sel[i] && flags[i]) skip = 1'b1;
        end
    end

    AST_SKIP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> (rx_ready_seen || tx_flag)) else $error("skip"); // R11

    logic rx_ready_seen;
    assign rx_ready_seen = rx_flag;

endmodule

// File: rtl/console_char_port.sv
module console_char_port
    import cterm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          kb_valid,
    input  logic [CW-1:0] kb_data,
    input  logic          kb_break,
    output logic [CW-1:0] rx_data,
    output logic          rx_ready,
    input  logic          cpu_wr_en,
    input  logic [CW-1:0] cpu_wr_data,
    output logic          tx_ready,
    input  logic          func_en,
    input  logic [1:0]    func_op,
    input  logic [1:0]    skip_sel,
    output logic          skip,
    output logic          prn_valid,
    output logic [CW-1:0] prn_data,
    input  logic          prn_ready
);

    cmode_e mode_e;
    logic   clr_rx, clr_tx;

    assign mode_e = cmode_e'(mode);
    assign clr_rx = func_en && func_op[0];
    assign clr_tx = func_en && func_op[1];

    cterm_rx_path u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_e),
        .kb_valid (kb_valid),
        .kb_data  (kb_data),
        .kb_break (kb_break),
        .clr_rdy  (clr_rx),
        .rx_data  (rx_data),
        .rx_ready (rx_ready)
    );

    cterm_tx_path u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_e),
        .wr_en     (cpu_wr_en),
        .wr_data   (cpu_wr_data),
        .clr_rdy   (clr_tx),
        .tx_ready  (tx_ready),
        .prn_valid (prn_valid),
        .prn_data  (prn_data),
        .prn_ready (prn_ready)
    );

    cterm_flag_test u_skip (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (skip_sel),
        .rx_flag (rx_ready),
        .tx_flag (tx_ready),
        .skip    (skip)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (rx_data == '0) && !rx_ready && tx_ready && !prn_valid) else $error("rst"); // R1

endmodule

// File: tb/console_char_port_tb_top.sv
module console_char_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b01;
    logic       kb_valid = 1'b0;
    logic [7:0] kb_data = 8'h00;
    logic       kb_break = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready;
    logic       cpu_wr_en = 1'b0;
    logic [7:0] cpu_wr_data = 8'h00;
    logic       tx_ready;
    logic       func_en = 1'b0;
    logic [1:0] func_op = 2'b00;
    logic [1:0] skip_sel = 2'b00;
    logic       skip;
    logic       prn_valid;
    logic [7:0] prn_data;
    logic       prn_ready = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    console_char_port dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .kb_valid(kb_valid), .kb_data(kb_data), .kb_break(kb_break),
        .rx_data(rx_data), .rx_ready(rx_ready),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .tx_ready(tx_ready),
        .func_en(func_en), .func_op(func_op), .skip_sel(skip_sel), .skip(skip),
        .prn_valid(prn_valid), .prn_data(prn_data), .prn_ready(prn_ready)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_fold(input logic [7:0] c);
        if (c >= 8'h61 && c <= 8'h7A) return c - 8'h20;
        return c;
    endfunction

    // Drive one keyboard character and sample after the capturing edge.
    task automatic send_kb(input logic [7:0] c);
        @(negedge clk);
        kb_valid = 1'b1; kb_data = c;
        @(negedge clk);
        kb_valid = 1'b0;
    endtask

    task automatic pulse_func(input logic [1:0] op);
        @(negedge clk);
        func_en = 1'b1; func_op = op;
        @(negedge clk);
        func_en = 1'b0; func_op = 2'b00;
    endtask

    task automatic write_tx(input logic [7:0] c);
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_wr_data = c;
        @(negedge clk);
        cpu_wr_en = 1'b0;
    endtask

    task automatic accept_tx;
        @(negedge clk);
        prn_ready = 1'b1;
        @(negedge clk);
        prn_ready = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rx_data", rx_data, 8'h00);
        chk("R1 rx_ready", {7'd0, rx_ready}, 8'h00);
        chk("R1 tx_ready", {7'd0, tx_ready}, 8'h01);
        chk("R1 prn_valid", {7'd0, prn_valid}, 8'h00);
    endtask

    task automatic t_rx_eight;
        mode = 2'b01;
        send_kb(8'hE1);
        chk("R2 rx eight", rx_data, 8'hE1);
        chk("R2 rx ready", {7'd0, rx_ready}, 8'h01);
    endtask

    task automatic t_rx_seven;
        mode = 2'b00;
        send_kb(8'hE1);
        chk("R3 rx seven", rx_data, 8'h61);
        mode = 2'b11;
        send_kb(8'hF5);
        chk("R3 rx spare", rx_data, 8'h75);
    endtask

    task automatic t_rx_tty;
        logic [7:0] probes [6] = '{8'h60, 8'h61, 8'h7A, 8'h7B, 8'hE2, 8'h35};
        mode = 2'b10;
        foreach (probes[i]) begin
            send_kb(probes[i]);
            chk("R4 rx tty", rx_data, ref_fold(probes[i] & 8'h7F) | 8'h80);
        end
    endtask

    task automatic t_break;
        mode = 2'b01;
        @(negedge clk);
        kb_break = 1'b1; kb_data = 8'h5A; kb_valid = 1'b1;
        @(negedge clk);
        kb_break = 1'b0; kb_valid = 1'b0;
        chk("R6 break data", rx_data, 8'h00);
        chk("R6 break ready", {7'd0, rx_ready}, 8'h01);
    endtask

    task automatic t_overwrite;
        mode = 2'b01;
        send_kb(8'h11);
        send_kb(8'h22);
        chk("R7 overwrite", rx_data, 8'h22);
        chk("R7 ready kept", {7'd0, rx_ready}, 8'h01);
    endtask

    task automatic t_func_and_skip;
        // rx_ready = 1, tx_ready = 1 here
        skip_sel = 2'b01; #1;
        chk("R11 skip rx", {7'd0, skip}, 8'h01);
        pulse_func(2'b01);
        chk("R10 rx clr", {7'd0, rx_ready}, 8'h00);
        chk("R10 data kept", rx_data, 8'h22);
        chk("R11 skip rx off", {7'd0, skip}, 8'h00);
        skip_sel = 2'b10; #1;
        chk("R11 skip tx", {7'd0, skip}, 8'h01);
        pulse_func(2'b10);
        chk("R10 tx clr", {7'd0, tx_ready}, 8'h00);
        skip_sel = 2'b11; #1;
        chk("R11 skip none", {7'd0, skip}, 8'h00);
        // clear and arrival together: arrival wins
        @(negedge clk);
        func_en = 1'b1; func_op = 2'b01; kb_valid = 1'b1; kb_data = 8'h33;
        @(negedge clk);
        func_en = 1'b0; func_op = 2'b00; kb_valid = 1'b0;
        chk("R10 arrival wins", {7'd0, rx_ready}, 8'h01);
        chk("R11 skip both", {7'd0, skip}, 8'h01);
        skip_sel = 2'b00;
    endtask

    task automatic t_tx_basic;
        mode = 2'b01;
        write_tx(8'hC8);
        chk("R8 tx_ready low", {7'd0, tx_ready}, 8'h00);
        chk("R8 prn_valid", {7'd0, prn_valid}, 8'h01);
        chk("R2 tx eight", prn_data, 8'hC8);
        repeat (3) @(negedge clk);
        chk("R9 stall valid", {7'd0, prn_valid}, 8'h01);
        chk("R9 stall data", prn_data, 8'hC8);
        chk("R9 stall ready", {7'd0, tx_ready}, 8'h00);
        accept_tx;
        chk("R9 done valid", {7'd0, prn_valid}, 8'h00);
        chk("R9 done ready", {7'd0, tx_ready}, 8'h01);
    endtask

    task automatic t_tx_modes;
        mode = 2'b00;
        write_tx(8'hE1);
        chk("R3 tx seven", prn_data, 8'h61);
        accept_tx;
        mode = 2'b10;
        write_tx(8'hE1);
        chk("R5 tx tty fold", prn_data, 8'h41);
        accept_tx;
        write_tx(8'h7B);
        chk("R5 tx tty edge", prn_data, 8'h7B);
        accept_tx;
        write_tx(8'h60);
        chk("R5 tx tty low edge", prn_data, 8'h60);
        accept_tx;
        chk("R9 ready after", {7'd0, tx_ready}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_rx_eight;
        t_rx_seven;
        t_rx_tty;
        t_break;
        t_overwrite;
        t_func_and_skip;
        t_tx_basic;
        t_tx_modes;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule